// File: doc/BRIEF.md
# Non-PCM Burst Packer

This block sits between an audio data FIFO and a sub-frame encoder on a link that carries compressed (non-linear) audio. On every sub-frame slot the encoder raises a one-cycle request, and the packer answers one clock later with one 16-bit word for that slot, with the validity flag set. The packer takes data bursts from the FIFO only after checking that they open with the two sync words. It then emits the burst, clips a payload that is too long for the programmed repetition period, and pads the rest of the period with zero words.

When no usable data is present the packer sends zero stuffing. Words that do not start a well-formed burst are dropped one per slot. While the FIFO stays empty, it inserts a four-word null burst (type 0, length 0) at a programmed interval. Every burst, data or null, opens with 0xF872 then 0x4E1F, followed by an info word and a length word. The length counts 16-bit payload words. The payload itself is passed through without interpretation.

Top module: `npk_burst_packer`

## Requirements
- R1: While reset is applied and after it is released, out_stb, out_word, out_vbit and burst_trunc are 0, and fifo_rd stays low until the first request.
- R2: Each cycle with sub_req high produces exactly one word, with out_stb high on the following cycle. With sub_req low, out_stb is low on the following cycle and fifo_rd is low.
- R3: A data burst is accepted only if the FIFO head is 0xF872 and the next FIFO word is 0xF872's partner 0xF872→0x4E1F. Its words then leave in this order: 0xF872, 0x4E1F, the info word, the length word, then the payload. The first 0xF872 is taken while a stuffing word 0x0000 goes out.
- R4: In the search state, any FIFO head other than 0xF872 is popped and replaced by 0x0000, one word per request. A held 0xF872 that is followed by something other than 0x4E1F is dropped, and that following word is examined again on the next request.
- R5: With cfg_rep_words = N > 0, a data burst together with its trailing 0x0000 fill spans exactly N words, counted from its first sync word. If the FIFO head is 0xF872 during the last fill word, it is taken at once, so the next burst starts exactly N words after the previous one.
- R6: With cfg_rep_words = 0, no fill words are sent and no clipping is done: the burst ends after its last payload word, and the full length is sent.
- R7: With N > 0, a length L > N−4 is sent as N−4 and only N−4 payload words are emitted. burst_trunc then reads 1 from that length word until the next length word, and the words left in the FIFO are discarded as in R4.
- R8: In the search state with the FIFO empty, after 2·cfg_null_gap stuffing or discard words since the last burst start, the next four words are 0xF872, 0x4E1F, 0x0000, 0x0000. cfg_null_gap = 0 disables null bursts.
- R9: out_vbit is 1 with every word delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_rep_words | input | PW | Repetition period in words; 0 disables fill and clipping |
| cfg_null_gap | input | GW | Null-burst interval in frames (two words each); 0 disables |
| sub_req | input | 1 | Request for the next sub-frame word |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_data | input | 16 | FIFO head word (show-ahead) |
| fifo_rd | output | 1 | Pop the FIFO head at this clock edge |
| out_word | output | 16 | Word for the current sub-frame |
| out_stb | output | 1 | out_word was produced for the request of the previous cycle |
| out_vbit | output | 1 | Validity flag sent with the word |
| burst_trunc | output | 1 | The most recent data burst had its payload clipped |

## Verification
The bench targets four areas: a lone 0xF872 followed by a foreign word, the exact spacing between two back-to-back bursts, a length that overflows the period, and the moment a null burst becomes due. If the sync filter were wrong, the foreign word would be swallowed or a half preamble would be forwarded. If the period look-ahead were wrong, the second burst would arrive one slot late. If clipping were wrong, a length word other than N−4 would appear, or fill would be missing. An off-by-one in the null interval would move the inserted 0xF872 by one slot. A second run with a zero period and a zero null gap checks that no fill and no null bursts appear.

// File: rtl/npk_pkg.sv
package npk_pkg;

  localparam int WORD_W = 16;

  // Preamble words that open every burst, in line order.
  localparam logic [WORD_W-1:0] SYNC_A = 16'hF872;
  localparam logic [WORD_W-1:0] SYNC_B = 16'h4E1F;

  // Header words before payload: two sync, info, length.
  localparam int HDR_WORDS = 4;

  typedef enum logic [3:0] {
    ST_HUNT,   // searching FIFO for a first sync word, sending stuffing
    ST_ARM,    // first sync held, waiting for the second
    ST_SYNC2,  // send second sync word
    ST_INFO,   // send info word
    ST_LEN,    // send (possibly clipped) length word
    ST_PAY,    // send payload words
    ST_FILL,   // zero fill to end of repetition period
    ST_N2,     // null burst, second sync
    ST_N3,     // null burst, info word
    ST_N4      // null burst, length word
  } npk_state_e;

endpackage

// File: rtl/npk_null_timer.sv
module npk_null_timer #(
  parameter int GW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          clr,
  input  logic [GW-1:0] gap,
  output logic          due
);

  logic [GW:0] cnt_q, cnt_d;
  logic [GW:0] limit;

  assign limit = {gap, 1'b0};
  assign due   = (gap != '0) && (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (step && (cnt_q != limit))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  // Once due, stays due until a burst start clears the count.
  p_due_holds_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (due && !clr) |=> due);

endmodule

// File: rtl/npk_len_clip.sv
module npk_len_clip #(
  parameter int PW = 16
) (
  input  logic [PW-1:0] rep,
  input  logic [PW-1:0] len_in,
  output logic [PW-1:0] len_out,
  output logic          trunc
);

  import npk_pkg::*;

  logic [PW-1:0] room;

  always_comb begin
    room    = (rep > PW'(HDR_WORDS)) ? rep - PW'(HDR_WORDS) : '0;
    len_out = len_in;
    trunc   = 1'b0;
    if ((rep != '0) && (len_in > room)) begin
      len_out = room;
      trunc   = 1'b1;
    end
  end

endmodule

// File: rtl/npk_period_ctr.sv
module npk_period_ctr #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          adv,
  input  logic          load,
  input  logic [PW-1:0] load_val,
  input  logic          dec,
  output logic [PW-1:0] pcnt,
  output logic [PW-1:0] rem
);

  logic [PW-1:0] pcnt_d, rem_d;

  always_comb begin
    pcnt_d = pcnt;
    if (start)
      pcnt_d = PW'(1);
    else if (adv)
      pcnt_d = pcnt + 1'b1;
  end

  always_comb begin
    rem_d = rem;
    if (load)
      rem_d = load_val;
    else if (dec && (rem != '0))
      rem_d = rem - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      rem  <= '0;
    end else begin
      pcnt <= pcnt_d;
      rem  <= rem_d;
    end
  end

endmodule

// File: rtl/npk_burst_packer.sv
module npk_burst_packer #(
  parameter int PW = 16,
  parameter int GW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] cfg_rep_words,
  input  logic [GW-1:0] cfg_null_gap,
  input  logic          sub_req,
  input  logic          fifo_empty,
  input  logic [15:0]   fifo_data,
  output logic          fifo_rd,
  output logic [15:0]   out_word,
  output logic          out_stb,
  output logic          out_vbit,
  output logic          burst_trunc
);

  import npk_pkg::*;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rs_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rs_q <= 2'b00;
    else
      rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  npk_state_e st, st_n;

  logic              pop;
  logic [WORD_W-1:0] word;
  logic              t_step, t_clr, null_due;
  logic              p_start, p_adv, pay_load, pay_dec, trunc_upd;
  logic [PW-1:0]     pcnt, rem, cnt_next;
  logic [PW-1:0]     len_in, clip_len;
  logic              clip_trunc, fill_more, head_sync_a, head_sync_b;

  assign head_sync_a = !fifo_empty && (fifo_data == SYNC_A);
  assign head_sync_b = !fifo_empty && (fifo_data == SYNC_B);
  assign len_in      = fifo_empty ? '0 : PW'(fifo_data);
  assign cnt_next    = pcnt + 1'b1;
  assign fill_more   = (cfg_rep_words != '0) && (cnt_next < cfg_rep_words);

  npk_len_clip #(.PW(PW)) u_clip (
    .rep     (cfg_rep_words),
    .len_in  (len_in),
    .len_out (clip_len),
    .trunc   (clip_trunc)
  );

  npk_period_ctr #(.PW(PW)) u_pctr (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .start    (p_start),
    .adv      (p_adv),
    .load     (pay_load),
    .load_val (clip_len),
    .dec      (pay_dec),
    .pcnt     (pcnt),
    .rem      (rem)
  );

  npk_null_timer #(.GW(GW)) u_ntmr (
    .clk   (clk),
    .rst_n (rst_i_n),
    .step  (t_step),
    .clr   (t_clr),
    .gap   (cfg_null_gap),
    .due   (null_due)
  );

  // Next-state and per-word decisions.
  always_comb begin
    st_n      = st;
    pop       = 1'b0;
    word      = '0;
    t_step    = 1'b0;
    t_clr     = 1'b0;
    p_start   = 1'b0;
    p_adv     = 1'b0;
    pay_load  = 1'b0;
    pay_dec   = 1'b0;
    trunc_upd = 1'b0;
    if (sub_req && rst_i_n) begin
      unique case (st)
        ST_HUNT: begin
          if (!fifo_empty) begin
            pop    = 1'b1;
            t_step = 1'b1;
            if (head_sync_a)
              st_n = ST_ARM;
          end else if (null_due) begin
            word  = SYNC_A;
            t_clr = 1'b1;
            st_n  = ST_N2;
          end else begin
            t_step = 1'b1;
          end
        end
        ST_ARM: begin
          if (head_sync_b) begin
            pop     = 1'b1;
            word    = SYNC_A;
            p_start = 1'b1;
            t_clr   = 1'b1;
            st_n    = ST_SYNC2;
          end else if (head_sync_a) begin
            pop = 1'b1;
          end else if (!fifo_empty) begin
            st_n = ST_HUNT;
          end
        end
        ST_SYNC2: begin
          word  = SYNC_B;
          p_adv = 1'b1;
          st_n  = ST_INFO;
        end
        ST_INFO: begin
          pop   = !fifo_empty;
          word  = fifo_empty ? '0 : fifo_data;
          p_adv = 1'b1;
          st_n  = ST_LEN;
        end
        ST_LEN: begin
          pop       = !fifo_empty;
          word      = WORD_W'(clip_len);
          pay_load  = 1'b1;
          trunc_upd = 1'b1;
          p_adv     = 1'b1;
          if (clip_len != '0)
            st_n = ST_PAY;
          else
            st_n = fill_more ? ST_FILL : ST_HUNT;
        end
        ST_PAY: begin
          pop     = !fifo_empty;
          word    = fifo_empty ? '0 : fifo_data;
          p_adv   = 1'b1;
          pay_dec = 1'b1;
          if (rem > PW'(1))
            st_n = ST_PAY;
          else
            st_n = fill_more ? ST_FILL : ST_HUNT;
        end
        ST_FILL: begin
          p_adv = 1'b1;
          if (!fill_more) begin
            if (head_sync_a) begin
              pop  = 1'b1;
              st_n = ST_ARM;
            end else begin
              st_n = ST_HUNT;
            end
          end
        end
        ST_N2: begin
          word = SYNC_B;
          st_n = ST_N3;
        end
        ST_N3: begin
          st_n = ST_N4;
        end
        ST_N4: begin
          if (head_sync_a) begin
            pop  = 1'b1;
            st_n = ST_ARM;
          end else begin
            st_n = ST_HUNT;
          end
        end
        default: st_n = ST_HUNT;
      endcase
    end
  end

  assign fifo_rd = pop;

  // Registers.
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st          <= ST_HUNT;
      out_word    <= '0;
      out_stb     <= 1'b0;
      out_vbit    <= 1'b0;
      burst_trunc <= 1'b0;
    end else begin
      st      <= st_n;
      out_stb <= sub_req;
      if (sub_req) begin
        out_word <= word;
        out_vbit <= 1'b1;
      end
      if (trunc_upd)
        burst_trunc <= clip_trunc;
    end
  end

  p_one_word_per_req_r2 : assert property (@(posedge clk) disable iff (!rst_i_n)
    sub_req |=> out_stb);

  p_no_word_without_req_r2 : assert property (@(posedge clk) disable iff (!rst_i_n)
    !sub_req |=> !out_stb);

  p_pop_only_when_avail_r4 : assert property (@(posedge clk) disable iff (!rst_i_n)
    fifo_rd |-> !fifo_empty);

  p_first_sync_out_r3 : assert property (@(posedge clk) disable iff (!rst_i_n)
    (st == ST_ARM && sub_req && head_sync_b) |=> (out_word == SYNC_A));

  p_second_sync_out_r3 : assert property (@(posedge clk) disable iff (!rst_i_n)
    (st == ST_SYNC2 && sub_req) |=> (out_word == SYNC_B && st == ST_INFO));

  p_fill_is_zero_r5 : assert property (@(posedge clk) disable iff (!rst_i_n)
    (st == ST_FILL && sub_req) |=> (out_word == '0));

  p_vbit_with_word_r9 : assert property (@(posedge clk) disable iff (!rst_i_n)
    out_stb |-> out_vbit);

endmodule

// File: tb/npk_burst_packer_test.sv
`timescale 1ns/1ps
module npk_burst_packer_test;

  logic        clk;
  logic        rst_n;
  logic [15:0] cfg_rep_words;
  logic [11:0] cfg_null_gap;
  logic        sub_req;
  logic        fifo_empty;
  logic [15:0] fifo_data;
  logic        fifo_rd;
  logic [15:0] out_word;
  logic        out_stb;
  logic        out_vbit;
  logic        burst_trunc;

  int n_chk;
  int n_bad;
  logic pend;
  logic [15:0] q [$];

  npk_burst_packer uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_rep_words (cfg_rep_words),
    .cfg_null_gap  (cfg_null_gap),
    .sub_req       (sub_req),
    .fifo_empty    (fifo_empty),
    .fifo_data     (fifo_data),
    .fifo_rd       (fifo_rd),
    .out_word      (out_word),
    .out_stb       (out_stb),
    .out_vbit      (out_vbit),
    .burst_trunc   (burst_trunc)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {push_en, push_word, expected_word, expected_trunc}; period 12, gap 3.
  localparam logic [33:0] VEC [0:48] = '{
    {1'b0,16'h0000,16'h0000,1'b0}, {1'b0,16'h0000,16'h0000,1'b0},
    {1'b0,16'h0000,16'h0000,1'b0}, {1'b0,16'h0000,16'h0000,1'b0},
    {1'b0,16'h0000,16'h0000,1'b0}, {1'b0,16'h0000,16'h0000,1'b0},
    {1'b0,16'h0000,16'hF872,1'b0}, {1'b0,16'h0000,16'h4E1F,1'b0},
    {1'b0,16'h0000,16'h0000,1'b0}, {1'b0,16'h0000,16'h0000,1'b0},
    {1'b1,16'h1234,16'h0000,1'b0}, {1'b1,16'hF872,16'h0000,1'b0},
    {1'b1,16'h5555,16'h0000,1'b0}, {1'b0,16'h0000,16'h0000,1'b0},
    {1'b1,16'hF872,16'h0000,1'b0}, {1'b1,16'h4E1F,16'hF872,1'b0},
    {1'b1,16'h0015,16'h4E1F,1'b0}, {1'b1,16'h0003,16'h0015,1'b0},
    {1'b1,16'hAAAA,16'h0003,1'b0}, {1'b1,16'hBBBB,16'hAAAA,1'b0},
    {1'b1,16'hCCCC,16'hBBBB,1'b0}, {1'b1,16'hF872,16'hCCCC,1'b0},
    {1'b1,16'h4E1F,16'h0000,1'b0}, {1'b0,16'h0000,16'h0000,1'b0},
    {1'b0,16'h0000,16'h0000,1'b0}, {1'b0,16'h0000,16'h0000,1'b0},
    {1'b0,16'h0000,16'h0000,1'b0}, {1'b1,16'h0007,16'hF872,1'b0},
    {1'b1,16'h000A,16'h4E1F,1'b0}, {1'b1,16'h0101,16'h0007,1'b0},
    {1'b1,16'h0202,16'h0008,1'b1}, {1'b1,16'h0303,16'h0101,1'b1},
    {1'b1,16'h0404,16'h0202,1'b1}, {1'b1,16'h0505,16'h0303,1'b1},
    {1'b1,16'h0606,16'h0404,1'b1}, {1'b1,16'h0707,16'h0505,1'b1},
    {1'b1,16'h0808,16'h0606,1'b1}, {1'b1,16'h0909,16'h0707,1'b1},
    {1'b1,16'h0A0A,16'h0808,1'b1}, {1'b0,16'h0000,16'h0000,1'b1},
    {1'b0,16'h0000,16'h0000,1'b1}, {1'b0,16'h0000,16'h0000,1'b1},
    {1'b0,16'h0000,16'h0000,1'b1}, {1'b0,16'h0000,16'h0000,1'b1},
    {1'b0,16'h0000,16'h0000,1'b1}, {1'b0,16'h0000,16'hF872,1'b1},
    {1'b0,16'h0000,16'h4E1F,1'b1}, {1'b0,16'h0000,16'h0000,1'b1},
    {1'b0,16'h0000,16'h0000,1'b1}
  };

  function automatic string step_tag(input int i);
    if (i < 10)       return "R8";
    else if (i < 15)  return "R4";
    else if (i < 22)  return "R3";
    else if (i < 27)  return "R5";
    else if (i < 39)  return "R7";
    else if (i < 41)  return "R4";
    else              return "R8";
  endfunction

  task automatic fifo_sync();
    fifo_empty = (q.size() == 0);
    fifo_data  = fifo_empty ? 16'h0000 : q[0];
  endtask

  task automatic push(input logic [15:0] w);
    q.push_back(w);
    fifo_sync();
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One request: drive at a falling edge, check at the next falling edge.
  task automatic req_step(input logic [15:0] exp_w, input logic exp_t, input string tag);
    @(negedge clk);
    sub_req = 1'b1;
    #1 pend = fifo_rd;
    @(negedge clk);
    sub_req = 1'b0;
    if (pend) begin
      void'(q.pop_front());
      fifo_sync();
      pend = 1'b0;
    end
    #1;
    chk({tag, " strobe R2"}, {31'd0, out_stb}, 32'd1);
    chk({tag, " word"}, {16'd0, out_word}, {16'd0, exp_w});
    chk({tag, " trunc R7"}, {31'd0, burst_trunc}, {31'd0, exp_t});
    chk({tag, " vbit R9"}, {31'd0, out_vbit}, 32'd1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 stb in reset", {31'd0, out_stb}, 32'd0);
    chk("R1 trunc in reset", {31'd0, burst_trunc}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 word after reset", {16'd0, out_word}, 32'd0);
    chk("R1 vbit after reset", {31'd0, out_vbit}, 32'd0);
    chk("R1 rd after reset", {31'd0, fifo_rd}, 32'd0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    pend = 1'b0;
    rst_n = 1'b1;
    sub_req = 1'b0;
    cfg_rep_words = 16'd12;
    cfg_null_gap = 12'd3;
    fifo_sync();
    #1 rst_n = 1'b0;

    do_reset();

    // Table walk: null bursts, discard, preamble, fill, clipping.
    for (int i = 0; i < 49; i++) begin
      @(negedge clk);
      if (VEC[i][33]) push(VEC[i][32:17]);
      req_step(VEC[i][16:1], VEC[i][0], step_tag(i));
    end

    // Reset clears the sticky clip flag (R1).
    cfg_rep_words = 16'd0;
    cfg_null_gap = 12'd0;
    do_reset();

    // No request, FIFO not empty: no pop and no word (R2).
    @(negedge clk);
    push(16'hF872);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #1;
      chk("R2 idle rd", {31'd0, fifo_rd}, 32'd0);
      chk("R2 idle stb", {31'd0, out_stb}, 32'd0);
    end

    // Zero period: no fill, no clipping (R6); gap 0: no null bursts (R8).
    push(16'h4E1F);
    push(16'h0011);
    push(16'h0005);
    for (int k = 1; k <= 5; k++) push(16'(k * 16'h1111));
    req_step(16'h0000, 1'b0, "R3 grab");
    req_step(16'hF872, 1'b0, "R6 sync a");
    req_step(16'h4E1F, 1'b0, "R6 sync b");
    req_step(16'h0011, 1'b0, "R6 info");
    req_step(16'h0005, 1'b0, "R6 length");
    for (int k = 1; k <= 5; k++) req_step(16'(k * 16'h1111), 1'b0, "R6 payload");
    for (int k = 0; k < 12; k++) req_step(16'h0000, 1'b0, "R6 R8 stuffing");

    finish_run();
  end

endmodule